// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of nonmaskable trap requests and a larger set of maskable peripheral requests, and reduces them to a single request towards a processor. Each maskable source has a 3-bit user priority level and an enable bit, written through a small configuration port. Every source has a pending flag that a one-cycle request pulse sets. A two-tier arbiter picks the winner. The higher effective priority wins first. Among equal priorities, the lower vector index wins. The winner is compared against the processor's current priority level.

For the winning source the block drives its vector index and the program-memory address of its vector slot. Traps take the lowest indices, 0 up to the trap count minus one. Maskable source `n` takes index `NUM_TRAP + n`. Slots are two address units apart. A control bit redirects every slot address from the default table to an alternate table that has the same layout. The processor takes an interrupt with a one-cycle acknowledge. That acknowledge clears the source's pending flag and raises the current level to the level of the taken source. A return strobe restores the previous level from a small stack. Request-to-vector latency is the same for every source.

Top module: `prio_vector_ctrl`

## Requirements
- R1: After reset, `irq_out` is 0, `cpu_ipl` is 0, the alternate-table bit is 0 and no source is pending.
- R2: A maskable source is presented only when it is enabled, pending, and its level is strictly greater than `cpu_ipl`; a source with level 0 is never presented.
- R3: Among presentable sources, the one with the higher priority is presented regardless of vector index.
- R4: Among presentable sources of equal priority, the one with the lower vector index is presented.
- R5: A pending trap has priority 8, is presented even when `cpu_ipl` is 8, and is presented ahead of every maskable source; among traps, the lowest index wins.
- R6: Maskable source `n` has `vec_idx` = NUM_TRAP + n (8 + n by default), and `vec_idx` k is mapped to `vec_addr` = 0x000004 + 2*k while the alternate bit is 0.
- R7: Bit 15 of a control write is the alternate-table bit; while it is 1, `vec_addr` = 0x000104 + 2*`vec_idx` for traps and interrupts alike, and the other control bits have no effect.
- R8: A request pulse sampled at clock edge n leaves `irq_out` low after edge n and raises `irq_out` after edge n+1, for traps and maskable sources alike.
- R9: `cpu_ack` while `irq_out` is 1 clears the presented source's pending flag, sets `cpu_ipl` to its priority (8 for a trap) and drops `irq_out` after that edge.
- R10: `cpu_ret` restores the level that was current before the most recent unreturned acknowledge (last in, first out).
- R11: `cpu_ret` with no saved level leaves `cpu_ipl` at 0, and `cpu_ack` while `irq_out` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | NUM_TRAP | Trap request pulses, bit i sets trap i pending |
| irq_req | input | NUM_IRQ | Maskable request pulses, bit n sets source n pending |
| cfg_we | input | 1 | Write strobe for one source's level and enable |
| cfg_sel | input | SEL_W | Maskable source number addressed by the write |
| cfg_level | input | 3 | User priority level, 0 disables |
| cfg_en | input | 1 | Source enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control data, bit 15 selects the alternate table |
| cpu_ack | input | 1 | One-cycle acknowledge of the presented vector |
| cpu_ret | input | 1 | One-cycle return-from-interrupt strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_idx | output | 7 | Vector index of the presented source |
| vec_addr | output | 24 | Program address of the presented vector slot |
| cpu_ipl | output | 4 | Current processor priority level |

## Verification
The checker asserts the following on every cycle:
- A presented maskable source always has a level above the current level.
- A maskable vector never appears while a trap was pending at the arbitration cycle.
- A presented trap carries priority 8.
- Slot addresses are even and in range.
- An acknowledge drops the request and loads the taken priority.
- A return never raises the level.

The directed scenarios show which source wins under a specific mix of levels and indices, and the exact slot addresses in each table. They also show the fixed two-edge latency, the nesting and unwinding order of the level stack, and that disabled or level-0 sources stay silent.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned ULVL_W = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [IDX_W-1:0]  vidx_t;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [ULVL_W-1:0] ulvl_t;

  localparam prio_t TRAP_PRIO = prio_t'(8);

  typedef struct packed {
    logic  vld;
    vidx_t idx;
    prio_t lvl;
  } win_t;

  // slot address: table base plus two units per vector index
  function automatic addr_t slot_addr(input addr_t base, input vidx_t idx);
    return base + (addr_t'(idx) << 1);
  endfunction

  // effective priority of a maskable source, zero when not presentable
  function automatic prio_t irq_prio(input logic en, input logic pend,
                                     input ulvl_t lvl, input prio_t ipl);
    prio_t wide;
    wide = prio_t'(lvl);
    return (en && pend && (wide > ipl)) ? wide : '0;
  endfunction

  // effective priority of a trap: never masked
  function automatic prio_t trap_prio(input logic pend);
    return pend ? TRAP_PRIO : '0;
  endfunction
endpackage

// File: rtl/pvc_pending.sv
module pvc_pending #(
  parameter int unsigned N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  // a new request in the same cycle as its clear keeps the flag set
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_o[g] <= 1'b0;
      else if (set_i[g])   pend_o[g] <= 1'b1;
      else if (clr_i[g])   pend_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pvc_arbiter.sv
module pvc_arbiter
  import pvc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 24
) (
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output win_t                           win_o
);
  // scan from the highest index down, ">=" lets lower indices take ties
  always_comb begin
    prio_t best;
    best  = '0;
    win_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (prio_i[i] != '0 && prio_i[i] >= best) begin
        best      = prio_i[i];
        win_o.vld = 1'b1;
        win_o.idx = vidx_t'(i);
        win_o.lvl = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/pvc_prio_stack.sv
module pvc_prio_stack
  import pvc_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_i,
  input  prio_t push_val_i,
  input  logic  pop_i,
  output prio_t cur_o,
  output logic  empty_o
);
  localparam int unsigned SP_W = $clog2(DEPTH + 1);
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][PRIO_W-1:0] saved;
  logic [SP_W-1:0]              sp;
  logic [SP_W-1:0]              top;

  assign top     = sp - SP_W'(1);
  assign empty_o = (sp == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saved <= '0;
      sp    <= '0;
      cur_o <= '0;
    end else if (push_i) begin
      // a push past the last slot loses the saved level
      if (sp < SP_W'(DEPTH)) begin
        saved[sp[AW-1:0]] <= cur_o;
        sp                <= sp + SP_W'(1);
      end
      cur_o <= push_val_i;
    end else if (pop_i) begin
      if (!empty_o) begin
        cur_o <= saved[top[AW-1:0]];
        sp    <= top;
      end else begin
        cur_o <= '0;
      end
    end
  end
endmodule

// File: rtl/prio_vector_ctrl.sv
module prio_vector_ctrl
  import pvc_pkg::*;
#(
  parameter int unsigned NUM_TRAP  = 8,
  parameter int unsigned NUM_IRQ   = 16,
  parameter int unsigned STK_DEPTH = 8,
  parameter logic [23:0] DEF_BASE  = 24'h000004,
  parameter logic [23:0] ALT_BASE  = 24'h000104,
  localparam int unsigned SEL_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRAP-1:0] trap_req,
  input  logic [NUM_IRQ-1:0]  irq_req,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [2:0]          cfg_level,
  input  logic                cfg_en,
  input  logic                ctl_we,
  input  logic [15:0]         ctl_wdata,
  input  logic                cpu_ack,
  input  logic                cpu_ret,
  output logic                irq_out,
  output logic [6:0]          vec_idx,
  output logic [23:0]         vec_addr,
  output logic [3:0]          cpu_ipl
);
  localparam int unsigned NUM_SRC = NUM_TRAP + NUM_IRQ;
  localparam int unsigned ALT_BIT = 15;

  // per-source configuration
  ulvl_t               src_lvl [NUM_IRQ];
  logic [NUM_IRQ-1:0]  src_en;
  logic                alt_q;

  // named internal events
  logic [NUM_SRC-1:0]              pend;
  logic [NUM_TRAP-1:0]             trap_pend;
  logic [NUM_IRQ-1:0]              irq_pend;
  logic [NUM_SRC-1:0]              clr_vec;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  eff_prio;
  win_t                            win;
  logic                            ack_take;
  logic                            ret_take;
  logic                            stk_empty;
  prio_t                           ipl;

  // registered presentation
  logic  out_vld;
  vidx_t out_idx;
  prio_t out_lvl;
  addr_t out_addr;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_lvl[g] <= '0;
        src_en[g]  <= 1'b0;
      end else if (cfg_we && int'(cfg_sel) == g) begin
        src_lvl[g] <= cfg_level;
        src_en[g]  <= cfg_en;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      alt_q <= 1'b0;
    else if (ctl_we) alt_q <= ctl_wdata[ALT_BIT];
  end

  assign ack_take = cpu_ack && out_vld;
  assign ret_take = cpu_ret && !ack_take;
  assign clr_vec  = ack_take ? (NUM_SRC'(1) << out_idx) : '0;

  pvc_pending #(.N(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  ({irq_req, trap_req}),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  assign trap_pend = pend[NUM_TRAP-1:0];
  assign irq_pend  = pend[NUM_SRC-1:NUM_TRAP];

  for (genvar t = 0; t < NUM_TRAP; t++) begin : g_trap_prio
    assign eff_prio[t] = trap_prio(trap_pend[t]);
  end
  for (genvar s = 0; s < NUM_IRQ; s++) begin : g_irq_prio
    assign eff_prio[NUM_TRAP + s] = irq_prio(src_en[s], irq_pend[s], src_lvl[s], ipl);
  end

  pvc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .prio_i (eff_prio),
    .win_o  (win)
  );

  pvc_prio_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (ack_take),
    .push_val_i (out_lvl),
    .pop_i      (ret_take),
    .cur_o      (ipl),
    .empty_o    (stk_empty)
  );

  // one register stage for every source: constant entry latency
  always_ff @(posedge clk) begin
    if (!rst_n || ack_take) begin
      out_vld  <= 1'b0;
      out_idx  <= '0;
      out_lvl  <= '0;
      out_addr <= '0;
    end else begin
      out_vld  <= win.vld;
      out_idx  <= win.idx;
      out_lvl  <= win.lvl;
      out_addr <= win.vld ? slot_addr(alt_q ? ALT_BASE : DEF_BASE, win.idx) : '0;
    end
  end

  assign irq_out  = out_vld;
  assign vec_idx  = out_idx;
  assign vec_addr = out_addr;
  assign cpu_ipl  = ipl;
endmodule

// File: rtl/pvc_checker.sv
module pvc_checker #(
  parameter int unsigned NUM_TRAP = 8,
  parameter int unsigned NUM_SRC  = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_out,
  input logic [6:0]          vec_idx,
  input logic [23:0]         vec_addr,
  input logic [3:0]          cpu_ipl,
  input logic [3:0]          out_lvl,
  input logic [NUM_TRAP-1:0] trap_pend,
  input logic                ack_take,
  input logic                ret_take
);
  a_r2_above_ipl: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && vec_idx >= 7'(NUM_TRAP)) |-> (out_lvl > cpu_ipl));

  a_r5_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && vec_idx >= 7'(NUM_TRAP)) |-> ($past(trap_pend) == '0));

  a_r5_trap_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && vec_idx < 7'(NUM_TRAP)) |-> (out_lvl == 4'd8));

  a_r6_addr_shape: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (vec_addr[0] == 1'b0 && vec_idx < 7'(NUM_SRC)));

  a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> !irq_out);

  a_r9_ack_level: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (cpu_ipl == $past(out_lvl)));

  a_r10_ret_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    ret_take |=> (cpu_ipl <= $past(cpu_ipl)));
endmodule

bind prio_vector_ctrl pvc_checker #(.NUM_TRAP(NUM_TRAP), .NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_out   (irq_out),
  .vec_idx   (vec_idx),
  .vec_addr  (vec_addr),
  .cpu_ipl   (cpu_ipl),
  .out_lvl   (out_lvl),
  .trap_pend (trap_pend),
  .ack_take  (ack_take),
  .ret_take  (ret_take)
);

// File: tb/test_prio_vector_ctrl.sv
`timescale 1ns/1ps
module test_prio_vector_ctrl;
  localparam int NT = 8;
  localparam int NI = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] trap_req = '0;
  logic [NI-1:0] irq_req = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_sel = '0;
  logic [2:0]    cfg_level = '0;
  logic          cfg_en = 1'b0;
  logic          ctl_we = 1'b0;
  logic [15:0]   ctl_wdata = '0;
  logic          cpu_ack = 1'b0;
  logic          cpu_ret = 1'b0;
  logic          irq_out;
  logic [6:0]    vec_idx;
  logic [23:0]   vec_addr;
  logic [3:0]    cpu_ipl;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  prio_vector_ctrl i_prio_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_level(cfg_level), .cfg_en(cfg_en),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .cpu_ack(cpu_ack), .cpu_ret(cpu_ret),
    .irq_out(irq_out), .vec_idx(vec_idx), .vec_addr(vec_addr), .cpu_ipl(cpu_ipl)
  );

  function automatic int exp_addr(input bit alt, input int idx);
    return (alt ? 32'h104 : 32'h4) + idx * 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic expect_vec(input string req, input int idx, input bit alt);
    chk(irq_out == 1'b1, req, int'(irq_out), 1);
    chk(int'(vec_idx) == idx, req, int'(vec_idx), idx);
    chk(int'(vec_addr) == exp_addr(alt, idx), req, int'(vec_addr), exp_addr(alt, idx));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input int n, input int lvl, input bit en);
    cfg_we = 1'b1; cfg_sel = 4'(n); cfg_level = 3'(lvl); cfg_en = en;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic ctl(input logic [15:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic ack();
    cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
  endtask

  task automatic ret();
    cpu_ret = 1'b1; tick(); cpu_ret = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 32; k++) begin
      if (irq_out) begin ack(); ret(); tick(); end
    end
  endtask

  task automatic t_reset();
    chk(irq_out == 1'b0, "R1 irq_out", int'(irq_out), 0);
    chk(cpu_ipl == 4'd0, "R1 cpu_ipl", int'(cpu_ipl), 0);
  endtask

  task automatic t_single_latency();
    cfg(2, 3, 1'b1);
    irq_req[2] = 1'b1; tick(); irq_req[2] = 1'b0;
    chk(irq_out == 1'b0, "R8 one edge", int'(irq_out), 0);
    tick();
    expect_vec("R6 R8 irq2", 10, 1'b0);
    drain();
    trap_req[4] = 1'b1; tick(); trap_req[4] = 1'b0;
    chk(irq_out == 1'b0, "R8 trap one edge", int'(irq_out), 0);
    tick();
    expect_vec("R8 trap4", 4, 1'b0);
    drain();
  endtask

  task automatic t_masking();
    cfg(6, 5, 1'b0);
    irq_req[6] = 1'b1; tick(); irq_req[6] = 1'b0; tick();
    chk(irq_out == 1'b0, "R2 disabled", int'(irq_out), 0);
    cfg(6, 5, 1'b1); tick();
    expect_vec("R2 R6 enabled later", 14, 1'b0);
    drain();
    cfg(7, 0, 1'b1);
    irq_req[7] = 1'b1; tick(); irq_req[7] = 1'b0; tick(); tick();
    chk(irq_out == 1'b0, "R2 level zero", int'(irq_out), 0);
  endtask

  task automatic t_levels();
    cfg(1, 2, 1'b1); cfg(5, 6, 1'b1);
    irq_req[1] = 1'b1; irq_req[5] = 1'b1; tick(); irq_req = '0; tick();
    expect_vec("R3 higher level wins", 13, 1'b0);
    ack();
    chk(irq_out == 1'b0, "R9 drop", int'(irq_out), 0);
    chk(cpu_ipl == 4'd6, "R9 level", int'(cpu_ipl), 6);
    tick();
    chk(irq_out == 1'b0, "R2 below ipl", int'(irq_out), 0);
    ret();
    chk(cpu_ipl == 4'd0, "R10 restore", int'(cpu_ipl), 0);
    tick();
    expect_vec("R10 lower source follows", 9, 1'b0);
    drain();
  endtask

  task automatic t_tie();
    cfg(4, 4, 1'b1); cfg(9, 4, 1'b1);
    irq_req[4] = 1'b1; irq_req[9] = 1'b1; tick(); irq_req = '0; tick();
    expect_vec("R4 tie lower index", 12, 1'b0);
    ack(); tick();
    chk(cpu_ipl == 4'd4, "R9 level", int'(cpu_ipl), 4);
    chk(irq_out == 1'b0, "R2 equal level blocked", int'(irq_out), 0);
    ret(); tick();
    expect_vec("R4 second of tie", 17, 1'b0);
    drain();
  endtask

  task automatic t_traps();
    cfg(3, 7, 1'b1);
    irq_req[3] = 1'b1; tick(); irq_req = '0; tick();
    expect_vec("R6 irq3", 11, 1'b0);
    ack();
    chk(cpu_ipl == 4'd7, "R9 level 7", int'(cpu_ipl), 7);
    cfg(0, 7, 1'b1);
    trap_req[5] = 1'b1; trap_req[2] = 1'b1; irq_req[0] = 1'b1;
    tick(); trap_req = '0; irq_req = '0; tick();
    expect_vec("R5 lowest trap", 2, 1'b0);
    ack();
    chk(cpu_ipl == 4'd8, "R5 trap level", int'(cpu_ipl), 8);
    tick();
    expect_vec("R5 trap above ipl 8", 5, 1'b0);
    ack(); tick();
    chk(irq_out == 1'b0, "R2 irq0 masked", int'(irq_out), 0);
    ret(); chk(cpu_ipl == 4'd8, "R10 pop 1", int'(cpu_ipl), 8);
    ret(); chk(cpu_ipl == 4'd7, "R10 pop 2", int'(cpu_ipl), 7);
    ret(); chk(cpu_ipl == 4'd0, "R10 pop 3", int'(cpu_ipl), 0);
    tick();
    expect_vec("R2 irq0 after unwind", 8, 1'b0);
    drain();
  endtask

  task automatic t_alt();
    ctl(16'h8000);
    cfg(0, 1, 1'b1);
    trap_req[0] = 1'b1; irq_req[0] = 1'b1; tick(); trap_req = '0; irq_req = '0; tick();
    expect_vec("R7 alt trap0", 0, 1'b1);
    ack(); ret(); tick();
    expect_vec("R7 alt irq0", 8, 1'b1);
    ctl(16'h7fff); tick();
    expect_vec("R7 only bit 15", 8, 1'b0);
    drain();
  endtask

  task automatic t_idle_strobes();
    ret();
    chk(cpu_ipl == 4'd0, "R11 ret empty", int'(cpu_ipl), 0);
    ack();
    chk(cpu_ipl == 4'd0, "R11 ack idle", int'(cpu_ipl), 0);
    tick();
    chk(irq_out == 1'b0, "R11 still idle", int'(irq_out), 0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single_latency();
    t_masking();
    t_levels();
    t_tie();
    t_traps();
    t_alt();
    t_idle_strobes();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule